// File: doc/BRIEF.md
# Grid Scan and Extension Driver Sequencer

This block sets the refresh timing of a grid-multiplexed display. A two-bit strap picks the scan length. The block then lights one grid at a time, in order, and wraps back to grid 0 after the last grid of the chosen length. Each grid slot has three parts: a dark gap, a single strobe cycle, and a lit period. During the strobe cycle, downstream logic loads the segment latch for the grid given on `grid_idx`.

The first `ON_GRIDS` grids are driven directly on chip through a one-hot enable vector. The longest scan needs more grids than that, so the rest go to an external shift-register grid driver through a serial port. The port has data, a clock that acts on its rising edge, an active-low clear, a latch pulse and an output enable. While one slot is lit, the block shifts out the external pattern for the next slot. It latches that pattern during the next strobe cycle. If the strap changes, the block runs a clear cycle and restarts the scan at grid 0.

Four states make up the controller:
- `ST_CLEAR` is the reset state and the restart state. It always moves to `ST_BLANK`.
- `ST_BLANK` counts the dark gap and then moves to `ST_LATCH`.
- `ST_LATCH` is the one-cycle strobe. It moves to `ST_SHOW`.
- `ST_SHOW` counts the lit period and then returns to `ST_BLANK` with the grid index advanced.

From any state other than `ST_CLEAR`, a strap change forces a move to `ST_CLEAR`.

Top module: `grid_scan_seq`

## Requirements
- R1: The strap code on `duty_sel` sets the scan length. The codes are 00 → 16 grids, 01 → 24 grids, 10 → 20 grids and 11 → 40 grids. `grid_idx` steps 0, 1, … up to length−1 and then wraps to 0.
- R2: Every slot is BLANK_CYCLES dark cycles, then one strobe cycle, then SHOW_CYCLES lit cycles. Consecutive strobes are BLANK_CYCLES+1+SHOW_CYCLES cycles apart. The first strobe after reset or a restart comes BLANK_CYCLES+1 cycles after it.
- R3: At most one bit of `grid_en` is high at any time. Bit k is high only during the lit period of slot k, where k < ON_GRIDS. All bits are low during the gap and during the strobe cycle.
- R4: `seg_load` is high for exactly one cycle at the start of each slot. During that cycle, `grid_idx` holds the index of the slot.
- R5: In 40-grid mode, the lit period of each slot shifts 16 bits, two clock cycles per bit. The data is stable when `ext_sclk` rises. The first bit shifted is for grid 39 and the last is for grid 24. `ext_latch` pulses in the strobe cycle. The external outputs then show grid k−24 one-hot for k ≥ 24, and all zeros otherwise.
- R6: `ext_oe` is high only during the lit period in 40-grid mode. It is low during the gap and the strobe cycle.
- R7: In the 16-, 20- and 24-grid modes the serial port is idle: `ext_sclk`, `ext_latch`, `ext_oe` and `ext_sdata` stay low and `ext_clr_n` stays high.
- R8: While reset is asserted, `grid_en`, `seg_load` and `ext_oe` are low and `ext_clr_n` is low. Asserting reset blanks the grids at once, without waiting for a clock.
- R9: When `duty_sel` changes, the next clock enters the clear state. In that state the grids are dark and `ext_clr_n` is low. The scan then restarts at grid 0 with the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_sel | input | 2 | Scan-length strap code |
| grid_en | output | ON_GRIDS | One-hot enable for the on-chip grids |
| seg_load | output | 1 | Slot-start strobe for the segment latch |
| grid_idx | output | IDX_W | Index of the current slot |
| ext_sdata | output | 1 | Serial data to the external grid driver |
| ext_sclk | output | 1 | Shift clock, rising-edge active |
| ext_clr_n | output | 1 | Clear for the external driver, active low |
| ext_latch | output | 1 | Moves shifted data into the external output latch |
| ext_oe | output | 1 | External outputs follow the latch when high and are low when low |

## Verification
The hardest case to reach is the handoff in 40-grid mode. The external pattern shown in slot k was shifted during slot k−1 and latched at the strobe of slot k. A wrong bit order or an off-by-one slot only shows up at grids 24 and 39, and at the wrap back to 0. The bench models the external shift register and latch from the port pins alone. It then walks every mode over one full scan plus one slot, so each boundary grid and each wrap is seen. Strap changes happen at arbitrary points, including in the middle of a lit slot, to exercise the restart path.

// File: rtl/gs_pkg.sv
package gs_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_BLANK = 2'd1,
        ST_LATCH = 2'd2,
        ST_SHOW  = 2'd3
    } gs_state_e;

    localparam logic [1:0] DUTY_WIDE = 2'b11;

    // Scan length for a strap code; the wide code uses every grid available.
    function automatic logic [7:0] gs_scan_len(input logic [1:0] code, input logic [7:0] total);
        logic [7:0] len;
        unique case (code)
            2'b00:   len = 8'd16;
            2'b01:   len = 8'd24;
            2'b10:   len = 8'd20;
            default: len = total;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/gs_fsm.sv
module gs_fsm
    import gs_pkg::*;
#(
    parameter int TOTAL        = 40,
    parameter int BLANK_CYCLES = 4,
    parameter int SHOW_CYCLES  = 40,
    parameter int IDX_W        = 6,
    parameter int CNT_W        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       duty_sel,
    output gs_state_e        state,
    output logic [CNT_W-1:0] cnt,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] nxt_idx,
    output logic [1:0]       duty_q
);

    localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYCLES - 1);
    localparam logic [CNT_W-1:0] SHOW_LAST  = CNT_W'(SHOW_CYCLES - 1);

    gs_state_e        state_n;
    logic [CNT_W-1:0] cnt_n;
    logic [IDX_W-1:0] idx_n;
    logic [1:0]       duty_n;
    logic [7:0]       len8;
    logic             at_last;
    logic             restart;

    assign len8    = gs_scan_len(duty_q, 8'(TOTAL));
    assign at_last = (8'(idx) + 8'd1) >= len8;
    assign nxt_idx = at_last ? '0 : idx + 1'b1;
    assign restart = (state != ST_CLEAR) && (duty_sel != duty_q);

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        idx_n   = idx;
        duty_n  = duty_q;
        if (restart) begin
            state_n = ST_CLEAR;
            cnt_n   = '0;
            idx_n   = '0;
        end else begin
            unique case (state)
                ST_CLEAR: begin
                    duty_n  = duty_sel;
                    state_n = ST_BLANK;
                    cnt_n   = '0;
                    idx_n   = '0;
                end
                ST_BLANK: begin
                    if (cnt == BLANK_LAST) begin
                        state_n = ST_LATCH;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_LATCH: begin
                    state_n = ST_SHOW;
                    cnt_n   = '0;
                end
                ST_SHOW: begin
                    if (cnt == SHOW_LAST) begin
                        state_n = ST_BLANK;
                        cnt_n   = '0;
                        idx_n   = nxt_idx;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_CLEAR;
            cnt    <= '0;
            idx    <= '0;
            duty_q <= 2'b00;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            idx    <= idx_n;
            duty_q <= duty_n;
        end
    end

    // R1: the index never leaves the selected scan length
    p_idx_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CLEAR) |-> (8'(idx) < len8));

    // R1: after the last grid's lit period the scan returns to grid 0
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHOW && cnt == SHOW_LAST && at_last && !restart) |=> (idx == '0));

    // R2: the strobe lasts one cycle and is followed by the lit period
    p_strobe_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && !restart) |=> (state == ST_SHOW));

    // R9: a strap change forces the clear state on the next cycle
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state == ST_CLEAR && idx == '0));

endmodule

// File: rtl/gs_grid_decode.sv
module gs_grid_decode
    import gs_pkg::*;
#(
    parameter int ON_GRIDS = 24,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  gs_state_e           state,
    input  logic [IDX_W-1:0]    idx,
    output logic [ON_GRIDS-1:0] grid_en
);

    for (genvar g = 0; g < ON_GRIDS; g++) begin : g_grid
        assign grid_en[g] = (state == ST_SHOW) && (idx == IDX_W'(g));
    end

    // R3: never two grids at once
    p_single_grid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_en));

    // R3: a lit on-chip grid means the scan index is inside the on-chip range
    p_grid_in_chip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|grid_en) |-> (int'(idx) < ON_GRIDS));

endmodule

// File: rtl/gs_ext_serializer.sv
module gs_ext_serializer
    import gs_pkg::*;
#(
    parameter int ON_GRIDS  = 24,
    parameter int EXT_GRIDS = 16,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gs_state_e        state,
    input  logic [CNT_W-1:0] cnt,
    input  logic [IDX_W-1:0] nxt_idx,
    input  logic             wide,
    output logic             sdata,
    output logic             sclk,
    output logic             clr_n,
    output logic             latch,
    output logic             oe
);

    localparam logic [CNT_W-1:0] SHIFT_END = CNT_W'(2 * EXT_GRIDS);
    localparam int               TOP_GRID  = ON_GRIDS + EXT_GRIDS - 1;

    logic [CNT_W-2:0] step;
    logic             in_shift;

    assign step     = cnt[CNT_W-1:1];
    assign in_shift = wide && (state == ST_SHOW) && (cnt < SHIFT_END);

    always_comb begin
        sdata = in_shift && (int'(nxt_idx) == TOP_GRID - int'(step));
        sclk  = in_shift && cnt[0];
        clr_n = (state != ST_CLEAR);
        latch = wide && (state == ST_LATCH);
        oe    = wide && (state == ST_SHOW);
    end

    // R5: serial data does not move while the shift clock rises
    p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdata));

    // R6: external outputs are enabled only after a latch pulse
    p_oe_after_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(latch));

    // R6: latch transfer happens while external outputs are dark
    p_latch_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> !oe);

endmodule

// File: rtl/grid_scan_seq.sv
module grid_scan_seq
    import gs_pkg::*;
#(
    parameter int ON_GRIDS     = 24,
    parameter int EXT_GRIDS    = 16,
    parameter int BLANK_CYCLES = 4,
    parameter int SHOW_CYCLES  = 40,
    parameter int TOTAL        = ON_GRIDS + EXT_GRIDS,
    parameter int IDX_W        = $clog2(TOTAL),
    parameter int MAX_CNT      = (SHOW_CYCLES > BLANK_CYCLES) ? SHOW_CYCLES : BLANK_CYCLES,
    parameter int CNT_W        = $clog2(MAX_CNT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          duty_sel,
    output logic [ON_GRIDS-1:0] grid_en,
    output logic                seg_load,
    output logic [IDX_W-1:0]    grid_idx,
    output logic                ext_sdata,
    output logic                ext_sclk,
    output logic                ext_clr_n,
    output logic                ext_latch,
    output logic                ext_oe
);

    gs_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] nxt_idx;
    logic [1:0]       duty_q;
    logic             wide;

    assign wide     = (duty_q == DUTY_WIDE);
    assign seg_load = (state == ST_LATCH);
    assign grid_idx = idx;

    gs_fsm #(
        .TOTAL(TOTAL), .BLANK_CYCLES(BLANK_CYCLES), .SHOW_CYCLES(SHOW_CYCLES),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .state(state),
        .cnt(cnt), .idx(idx), .nxt_idx(nxt_idx), .duty_q(duty_q)
    );

    gs_grid_decode #(.ON_GRIDS(ON_GRIDS), .IDX_W(IDX_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .state(state), .idx(idx), .grid_en(grid_en)
    );

    gs_ext_serializer #(
        .ON_GRIDS(ON_GRIDS), .EXT_GRIDS(EXT_GRIDS), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt), .nxt_idx(nxt_idx),
        .wide(wide), .sdata(ext_sdata), .sclk(ext_sclk), .clr_n(ext_clr_n),
        .latch(ext_latch), .oe(ext_oe)
    );

    // R4: the slot strobe is a single-cycle pulse
    p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_load |=> !seg_load);

    // R7: narrow modes leave the serial port idle
    p_port_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q != DUTY_WIDE) |-> (!ext_sclk && !ext_oe && !ext_sdata));

endmodule

// File: tb/grid_scan_seq_tb.sv
module grid_scan_seq_tb;

    localparam int ON     = 24;
    localparam int EXT    = 16;
    localparam int BLK    = 4;
    localparam int SHOW   = 40;
    localparam int PERIOD = BLK + 1 + SHOW;

    // stimulus table: {strap code, expected scan length}
    localparam logic [8:0] VEC [4] = '{{2'b00, 7'd16}, {2'b11, 7'd40}, {2'b01, 7'd24}, {2'b10, 7'd20}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    duty = 2'b00;
    logic [ON-1:0] grid_en;
    logic          seg_load;
    logic [5:0]    grid_idx;
    logic          ext_sdata, ext_sclk, ext_clr_n, ext_latch, ext_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_strobe = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    grid_scan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .duty_sel(duty), .grid_en(grid_en),
        .seg_load(seg_load), .grid_idx(grid_idx), .ext_sdata(ext_sdata),
        .ext_sclk(ext_sclk), .ext_clr_n(ext_clr_n), .ext_latch(ext_latch), .ext_oe(ext_oe)
    );

    // model of the external shift-register grid driver, built from its pins only
    logic [EXT-1:0] ext_sr, ext_lat;
    always @(posedge ext_sclk or negedge ext_clr_n)
        if (!ext_clr_n) ext_sr <= '0; else ext_sr <= {ext_sr[EXT-2:0], ext_sdata};
    always @(posedge ext_latch or negedge ext_clr_n)
        if (!ext_clr_n) ext_lat <= '0; else ext_lat <= ext_sr;
    wire [EXT-1:0] ext_out = ext_oe ? ext_lat : '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_strobe(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!seg_load && waited < 400);
        if (!seg_load) chk("R2 strobe watchdog", 0, 1);
    endtask

    // walk one slot after its strobe was seen; k is the expected grid index
    task automatic check_slot(input int k, input bit wide);
        logic [ON-1:0]  exp_grid;
        logic [EXT-1:0] exp_ext;
        exp_grid = (k < ON) ? (ON'(1) << k) : '0;
        exp_ext  = (wide && k >= ON) ? (EXT'(1) << (k - ON)) : '0;
        chk("R4 grid_idx at strobe", 64'(grid_idx), 64'(k));
        chk("R3 dark during strobe", 64'(grid_en), 0);
        @(negedge clk);
        chk("R4 strobe single cycle", 64'(seg_load), 0);
        chk("R3 grid_en lit", 64'(grid_en), 64'(exp_grid));
        chk("R6 ext_oe in lit period", 64'(ext_oe), 64'(wide));
        if (wide) chk("R5 external grid pattern", 64'(ext_out), 64'(exp_ext));
        repeat (3) @(negedge clk);
        if (wide) chk("R5 shift clock high mid bit", 64'(ext_sclk), 1);
        else chk("R7 port idle", 64'({ext_sclk, ext_latch, ext_oe, ext_sdata, ext_clr_n}), 64'(5'b00001));
        repeat (SHOW - 3) @(negedge clk);
        chk("R3 dark in gap", 64'(grid_en), 0);
        chk("R6 ext_oe low in gap", 64'(ext_oe), 0);
    endtask

    initial begin
        #(20 * 150000);
        chk("watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w;
        logic [1:0] prev;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 grid_en in reset", 64'(grid_en), 0);
        chk("R8 seg_load in reset", 64'(seg_load), 0);
        chk("R8 ext_oe in reset", 64'(ext_oe), 0);
        chk("R8 ext_clr_n in reset", 64'(ext_clr_n), 0);
        rst_n = 1'b1;
        prev = 2'b00;

        for (int vi = 0; vi < 4; vi++) begin
            logic [1:0] code;
            int n;
            code = VEC[vi][8:7];
            n    = int'(VEC[vi][6:0]);
            if (code != prev) begin
                duty = code;
                @(negedge clk);
                chk("R9 clear on strap change", 64'(ext_clr_n), 0);
                chk("R9 dark on strap change", 64'(grid_en), 0);
            end
            prev = code;
            for (int s = 0; s <= n; s++) begin
                wait_strobe(w);
                if (s == 0) chk("R2 first strobe delay", 64'(w), 64'(BLK + 1));
                else chk("R2 slot period", 64'(cyc - last_strobe), 64'(PERIOD));
                last_strobe = cyc;
                check_slot(s % n, code == 2'b11); // R1 order and wrap, R5 in wide mode
            end
        end

        // R9: strap change in the middle of a lit slot (currently 20-grid mode)
        wait_strobe(w);
        repeat (5) @(negedge clk);
        duty = 2'b11;
        @(negedge clk);
        chk("R9 mid-slot clear", 64'(ext_clr_n), 0);
        chk("R9 mid-slot dark", 64'(grid_en), 0);
        wait_strobe(w);
        chk("R9 restart delay", 64'(w), 64'(BLK + 1));
        check_slot(0, 1'b1);

        // R8: asynchronous reset while a grid is lit
        wait_strobe(w);
        @(negedge clk);
        chk("R8 lit before reset", 64'(grid_en), 64'(ON'(1) << 1));
        rst_n = 1'b0;
        #1;
        chk("R8 async blank grid_en", 64'(grid_en), 0);
        chk("R8 async ext_oe", 64'(ext_oe), 0);
        chk("R8 async clear", 64'(ext_clr_n), 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_strobe(w);
        chk("R8 first strobe after reset", 64'(w), 64'(BLK + 1));
        chk("R1 restart at grid 0", 64'(grid_idx), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule